// File: doc/BRIEF.md
# Parallel-Port Reverse Channel Receiver with Run-Length Expansion

This block is the host side of the reverse (peripheral-to-host) direction of an IEEE 1284 enhanced-capability parallel link. On request it turns the bus around from host-driven to peripheral-driven. It then takes in bytes with a two-wire handshake: the peripheral pulls nAck low to present a byte, and the host answers by raising nAutoFd. The level of Busy at that moment tells a data byte from a command byte.

Command bytes whose top bit is clear carry a run count. The data byte that follows one is delivered once and then repeated that many more times on a valid/ready output stream. Command bytes with the top bit set select a channel and are discarded. Every wait for the peripheral is bounded by a tick-based limit, and a missed limit raises a one-cycle timeout pulse. A second request hands the bus back to the host and clears any pending run.

All peripheral inputs are assumed to be already synchronised to `clk`. `tick_i` is the timebase for every limit.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, nStrobe, nAutoFd, nInit and nSelectIn are all high, the host drives the data bus (`data_oe_o`=1), `out_valid_o`=0 and `reverse_o`=0.
- R2: A `rev_req_i` in forward idle drives nAutoFd low and releases the bus (`data_oe_o`=0) on the next cycle. After SETUP_TICKS ticks it drives nInit low, with nStrobe and nSelectIn held high. When PError is seen low, `reverse_o` goes to 1.
- R3: If PError does not go low within RESP_TICKS ticks of nInit falling, `timeout_o` pulses for one cycle and the pins return to the forward idle state of R1.
- R4: When nAck is low and Busy is high, the bus byte is data. It is presented on `out_data_o` with `out_valid_o`=1 and held stable until `out_ready_i` accepts it. This applies to any value, including ones with bit 7 set.
- R5: After a byte is consumed, nAutoFd goes high until nAck is seen high, and then goes low again. If nAck stays low for RESP_TICKS ticks, `timeout_o` pulses, nAutoFd goes low, and no new byte is sampled until nAck has returned high.
- R6: If no byte arrives within IDLE_TICKS ticks while idle in reverse, `timeout_o` pulses and the block stays in reverse, ready for the next byte.
- R7: A command byte (Busy low) with bit 7 = 0 stores bits 6:0 as a run count N. The next data byte is emitted N+1 times in total.
- R8: A command byte with bit 7 = 1 produces no output and leaves a pending run count untouched.
- R9: Repeat emission is paced by `out_ready_i`. No copy is lost or duplicated across stalls.
- R10: A run count of 0 yields a single copy. Once a run has been expanded, later data bytes are emitted once each.
- R11: A `fwd_req_i` in reverse idle raises nInit and waits up to RESP_TICKS ticks for PError high. It then raises nAutoFd and drives the bus again (`data_oe_o`=1). If PError stays low, `timeout_o` pulses but the handover still completes.
- R12: Completing the handover to forward clears any pending run count, so a data byte received after the next reverse entry is emitted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe for all wait limits |
| rev_req_i | input | 1 | Request turnaround to reverse |
| fwd_req_i | input | 1 | Request turnaround back to forward |
| ack_n_i | input | 1 | Peripheral nAck |
| busy_i | input | 1 | Peripheral Busy (1 = data, 0 = command) |
| perror_i | input | 1 | Peripheral PError |
| data_i | input | DATA_W | Data bus as driven by the peripheral |
| strobe_n_o | output | 1 | Host nStrobe |
| autofd_n_o | output | 1 | Host nAutoFd |
| init_n_o | output | 1 | Host nInit |
| selectin_n_o | output | 1 | Host nSelectIn |
| data_oe_o | output | 1 | 1 = host drives the data bus |
| reverse_o | output | 1 | Reverse channel established |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_data_o | output | DATA_W | Output byte |
| timeout_o | output | 1 | One-cycle pulse on any expired wait |

## Verification
The bench attacks the run-length corner cases. A run count of zero must give one copy, and a design that repeats it as 256 or as 1 shows up as extra bytes. A channel-address byte lands between a count and its data byte, and a design that treats it as a new count emits the wrong number of copies. A stale count survives a forward/reverse round trip, and a design that fails to clear it emits phantom copies. The output stalls during repeats, which exposes copies dropped or doubled when ready is low.

Each timeout path is provoked in turn: the turnaround, the acknowledge, the idle wait and the handback. This catches designs that hang, that leave nAutoFd high, or that resample a byte still held under nAck.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

    typedef enum logic [3:0] {
        ST_FWD,
        ST_TA_SETUP,
        ST_TA_WAIT,
        ST_REV_WAIT,
        ST_EMIT,
        ST_ACK,
        ST_FLUSH,
        ST_REPEAT,
        ST_RF_WAIT
    } rx_state_e;

    typedef struct packed {
        logic strobe_n;
        logic autofd_n;
        logic init_n;
        logic selin_n;
        logic drive;
    } pin_ctl_t;

    function automatic pin_ctl_t pins_for(rx_state_e st);
        pin_ctl_t p;
        p.strobe_n = 1'b1;
        p.selin_n  = 1'b1;
        unique case (st)
            ST_FWD:      begin p.autofd_n = 1'b1; p.init_n = 1'b1; p.drive = 1'b1; end
            ST_TA_SETUP: begin p.autofd_n = 1'b0; p.init_n = 1'b1; p.drive = 1'b0; end
            ST_ACK:      begin p.autofd_n = 1'b1; p.init_n = 1'b0; p.drive = 1'b0; end
            ST_RF_WAIT:  begin p.autofd_n = 1'b0; p.init_n = 1'b1; p.drive = 1'b0; end
            default:     begin p.autofd_n = 1'b0; p.init_n = 1'b0; p.drive = 1'b0; end
        endcase
        return p;
    endfunction

    function automatic logic in_reverse(rx_state_e st);
        return (st == ST_REV_WAIT) || (st == ST_EMIT) || (st == ST_ACK) ||
               (st == ST_FLUSH) || (st == ST_REPEAT);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/ecp_run_ctl.sv
module ecp_run_ctl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              count_load_i,
    input  logic [DATA_W-2:0] count_i,
    input  logic              data_fire_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rep_take_i,
    output logic              rep_left_o,
    output logic              rep_last_o,
    output logic [DATA_W-1:0] rep_byte_o,
    output logic              armed_o
);
    localparam int RUN_W = DATA_W - 1;

    logic             armed_q;
    logic [RUN_W-1:0] run_cnt_q;
    logic [RUN_W-1:0] remain_q;
    logic [DATA_W-1:0] rep_byte_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            armed_q    <= 1'b0;
            run_cnt_q  <= '0;
            remain_q   <= '0;
            rep_byte_q <= '0;
        end else begin
            if (count_load_i) begin
                run_cnt_q <= count_i;
                armed_q   <= 1'b1;
            end else if (data_fire_i && armed_q) begin
                remain_q   <= run_cnt_q;
                rep_byte_q <= data_i;
                run_cnt_q  <= '0;
                armed_q    <= 1'b0;
            end
            if (rep_take_i && (remain_q != '0)) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign rep_left_o = (remain_q != '0);
    assign rep_last_o = (remain_q == RUN_W'(1));
    assign rep_byte_o = rep_byte_q;
    assign armed_o    = armed_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecp_rev_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SETUP_TICKS = 1,
    parameter int RESP_TICKS  = 6,
    parameter int IDLE_TICKS  = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rev_req_i,
    input  logic              fwd_req_i,
    input  logic              ack_n_i,
    input  logic              busy_i,
    input  logic              perror_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              strobe_n_o,
    output logic              autofd_n_o,
    output logic              init_n_o,
    output logic              selectin_n_o,
    output logic              data_oe_o,
    output logic              reverse_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              timeout_o
);
    localparam int MAX_TICKS = max_of(max_of(SETUP_TICKS, RESP_TICKS), IDLE_TICKS);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_SETUP = CNT_W'(SETUP_TICKS);
    localparam logic [CNT_W-1:0] LIM_RESP  = CNT_W'(RESP_TICKS);
    localparam logic [CNT_W-1:0] LIM_IDLE  = CNT_W'(IDLE_TICKS);

    rx_state_e   st_q, nxt;
    pin_ctl_t    pins_q;
    logic [DATA_W-1:0] cap_q;
    logic        tmo_q;

    logic [CNT_W-1:0] limit;
    logic        tmr_exp, tmr_restart, re_arm;
    logic        tmo_evt, cap_en, cmd_load, data_fire, rep_take, run_clr;
    logic        rep_left, rep_last, run_armed;
    logic [DATA_W-1:0] rep_byte;

    ecp_tick_timer #(.CNT_W(CNT_W)) timer_i (
        .clk       (clk),
        .rst       (rst),
        .restart_i (tmr_restart),
        .tick_i    (tick_i),
        .limit_i   (limit),
        .expired_o (tmr_exp)
    );

    ecp_run_ctl #(.DATA_W(DATA_W)) run_i (
        .clk          (clk),
        .rst          (rst),
        .clr_i        (run_clr),
        .count_load_i (cmd_load),
        .count_i      (data_i[DATA_W-2:0]),
        .data_fire_i  (data_fire),
        .data_i       (cap_q),
        .rep_take_i   (rep_take),
        .rep_left_o   (rep_left),
        .rep_last_o   (rep_last),
        .rep_byte_o   (rep_byte),
        .armed_o      (run_armed)
    );

    always_comb begin
        nxt       = st_q;
        limit     = LIM_RESP;
        tmo_evt   = 1'b0;
        re_arm    = 1'b0;
        cap_en    = 1'b0;
        cmd_load  = 1'b0;
        data_fire = 1'b0;
        rep_take  = 1'b0;
        run_clr   = 1'b0;
        unique case (st_q)
            ST_FWD: begin
                if (rev_req_i) nxt = ST_TA_SETUP;
            end
            ST_TA_SETUP: begin
                limit = LIM_SETUP;
                if (tmr_exp) nxt = ST_TA_WAIT;
            end
            ST_TA_WAIT: begin
                if (!perror_i) begin
                    nxt = ST_REV_WAIT;
                end else if (tmr_exp) begin
                    tmo_evt = 1'b1;
                    nxt     = ST_FWD;
                end
            end
            ST_REV_WAIT: begin
                limit = LIM_IDLE;
                if (!ack_n_i) begin
                    cap_en = 1'b1;
                    if (busy_i) begin
                        nxt = ST_EMIT;
                    end else begin
                        cmd_load = !data_i[DATA_W-1];
                        nxt      = ST_ACK;
                    end
                end else if (fwd_req_i) begin
                    nxt = ST_RF_WAIT;
                end else if (tmr_exp) begin
                    tmo_evt = 1'b1;
                    re_arm  = 1'b1;
                end
            end
            ST_EMIT: begin
                if (out_ready_i) begin
                    data_fire = 1'b1;
                    nxt       = ST_ACK;
                end
            end
            ST_ACK: begin
                if (ack_n_i) begin
                    nxt = rep_left ? ST_REPEAT : ST_REV_WAIT;
                end else if (tmr_exp) begin
                    tmo_evt = 1'b1;
                    nxt     = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (ack_n_i) nxt = rep_left ? ST_REPEAT : ST_REV_WAIT;
            end
            ST_REPEAT: begin
                if (out_ready_i) begin
                    rep_take = 1'b1;
                    if (rep_last) nxt = ST_REV_WAIT;
                end
            end
            ST_RF_WAIT: begin
                if (perror_i || tmr_exp) begin
                    tmo_evt = !perror_i;
                    run_clr = 1'b1;
                    nxt     = ST_FWD;
                end
            end
            default: nxt = ST_FWD;
        endcase
    end

    assign tmr_restart = (nxt != st_q) || re_arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_FWD;
            pins_q <= pins_for(ST_FWD);
            cap_q  <= '0;
            tmo_q  <= 1'b0;
        end else begin
            st_q   <= nxt;
            pins_q <= pins_for(nxt);
            tmo_q  <= tmo_evt;
            if (cap_en) cap_q <= data_i;
        end
    end

    assign strobe_n_o   = pins_q.strobe_n;
    assign autofd_n_o   = pins_q.autofd_n;
    assign init_n_o     = pins_q.init_n;
    assign selectin_n_o = pins_q.selin_n;
    assign data_oe_o    = pins_q.drive;
    assign reverse_o    = in_reverse(st_q);
    assign out_valid_o  = (st_q == ST_EMIT) || (st_q == ST_REPEAT);
    assign out_data_o   = (st_q == ST_REPEAT) ? rep_byte : cap_q;
    assign timeout_o    = tmo_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_n_o,
    input logic              autofd_n_o,
    input logic              init_n_o,
    input logic              selectin_n_o,
    input logic              data_oe_o,
    input logic              reverse_o,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic [DATA_W-1:0] out_data_o,
    input logic              timeout_o
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (strobe_n_o && autofd_n_o && init_n_o && selectin_n_o &&
                        data_oe_o && !out_valid_o && !reverse_o));

    a_r2_no_drive_init_low: assert property (@(posedge clk) disable iff (rst)
        !init_n_o |-> !data_oe_o);

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    a_r9_valid_in_reverse: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (reverse_o && !data_oe_o));

    a_r11_forward_restores: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe_o) |-> (autofd_n_o && init_n_o));

    a_r3_timeout_single: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .strobe_n_o   (strobe_n_o),
    .autofd_n_o   (autofd_n_o),
    .init_n_o     (init_n_o),
    .selectin_n_o (selectin_n_o),
    .data_oe_o    (data_oe_o),
    .reverse_o    (reverse_o),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_data_o   (out_data_o),
    .timeout_o    (timeout_o)
);

// File: tb/ecp_rev_rx_tb_top.sv
module ecp_rev_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RESP = 6;
    localparam int IDLE = 2000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rev_req = 1'b0, fwd_req = 1'b0;
    logic ack_n = 1'b1, busy = 1'b0, perror = 1'b1;
    logic [7:0] bus_d = '0;
    logic out_ready = 1'b1;
    logic strobe_n_o, autofd_n_o, init_n_o, selectin_n_o, data_oe_o, reverse_o;
    logic out_valid_o, timeout_o;
    logic [7:0] out_data_o;

    int n_vec = 0, n_bad = 0, tmo_cnt = 0;
    bit stall_en = 1'b0;
    logic [2:0] rdy_ph = '0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ecp_rev_rx #(.DATA_W(8), .SETUP_TICKS(1), .RESP_TICKS(RESP), .IDLE_TICKS(IDLE)) dut_i (
        .clk(clk), .rst(rst), .tick_i(1'b1), .rev_req_i(rev_req), .fwd_req_i(fwd_req),
        .ack_n_i(ack_n), .busy_i(busy), .perror_i(perror), .data_i(bus_d),
        .strobe_n_o(strobe_n_o), .autofd_n_o(autofd_n_o), .init_n_o(init_n_o),
        .selectin_n_o(selectin_n_o), .data_oe_o(data_oe_o), .reverse_o(reverse_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_data_o(out_data_o),
        .timeout_o(timeout_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        #1;
        rdy_ph    <= rdy_ph + 1'b1;
        out_ready <= stall_en ? (rdy_ph[1:0] == 2'd0) : 1'b1;
    end

    // scoreboard monitor (R4, R7, R8, R9, R10, R12)
    always @(negedge clk) begin
        if (!rst && timeout_o) tmo_cnt++;
        if (!rst && out_valid_o && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R10/R12 unexpected byte", {24'd0, out_data_o}, 32'hFFFF);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data_o == e, "R4/R9 output byte", {24'd0, out_data_o}, {24'd0, e});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_sig(input int sel, input logic val, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            case (sel)
                0: ok = (autofd_n_o == val);
                1: ok = (init_n_o == val);
                2: ok = (data_oe_o == val);
                default: ok = (reverse_o == val);
            endcase
            if (ok) break;
        end
    endtask

    task automatic go_reverse();
        bit ok;
        step(); rev_req = 1'b1;
        step(); rev_req = 1'b0;
        @(negedge clk);
        check(!autofd_n_o && !data_oe_o && init_n_o, "R2 nAutoFd low, bus released",
              {autofd_n_o, data_oe_o, init_n_o}, 3'b001);
        wait_sig(1, 1'b0, 5, ok);
        check(ok && strobe_n_o && selectin_n_o, "R2 nInit low, nStrobe/nSelectIn high",
              {init_n_o, strobe_n_o, selectin_n_o}, 3'b011);
        step(); perror = 1'b0;
        wait_sig(3, 1'b1, 4, ok);
        check(ok, "R2 reverse established", reverse_o, 1);
    endtask

    task automatic go_forward(input bit respond);
        bit ok;
        int t0;
        t0 = tmo_cnt;
        step(); fwd_req = 1'b1;
        step(); fwd_req = 1'b0;
        wait_sig(1, 1'b1, 5, ok);
        check(ok, "R11 nInit raised", init_n_o, 1);
        if (respond) begin step(); perror = 1'b1; end
        wait_sig(2, 1'b1, RESP + 6, ok);
        @(negedge clk);
        check(ok && autofd_n_o && !reverse_o, "R11 forward restored",
              {data_oe_o, autofd_n_o, reverse_o}, 3'b110);
        check((tmo_cnt - t0) == (respond ? 0 : 1), "R11 handback timeout count", tmo_cnt - t0, respond ? 0 : 1);
        if (!respond) begin step(); perror = 1'b1; end
    endtask

    task automatic send(input bit is_data, input logic [7:0] b, input bit hold);
        bit ok;
        wait_sig(0, 1'b0, 50, ok);
        step(); bus_d = b; busy = is_data; ack_n = 1'b0;
        wait_sig(0, 1'b1, 400, ok);
        check(ok, "R5 nAutoFd raised for byte", autofd_n_o, 1);
        if (!hold) begin
            step(); ack_n = 1'b1;
            wait_sig(0, 1'b0, 20, ok);
            check(ok, "R5 nAutoFd dropped after nAck high", autofd_n_o, 0);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        int t0;
        bit ok;
        repeat (4) step();
        rst = 1'b0;
        @(negedge clk);
        check(strobe_n_o && autofd_n_o && init_n_o && selectin_n_o && data_oe_o &&
              !out_valid_o && !reverse_o && !timeout_o, "R1 reset state",
              {strobe_n_o, autofd_n_o, init_n_o, selectin_n_o, data_oe_o, out_valid_o, reverse_o}, 7'b1111100);

        // R3: peripheral never lowers PError during turnaround
        t0 = tmo_cnt;
        step(); rev_req = 1'b1;
        step(); rev_req = 1'b0;
        wait_sig(1, 1'b0, 5, ok);
        repeat (RESP - 2) @(negedge clk);
        check(tmo_cnt == t0, "R3 no early timeout", tmo_cnt - t0, 0);
        repeat (8) @(negedge clk);
        check(tmo_cnt == t0 + 1, "R3 turnaround timeout", tmo_cnt - t0, 1);
        check(data_oe_o && autofd_n_o && init_n_o && !reverse_o, "R3 back to forward idle",
              {data_oe_o, autofd_n_o, init_n_o, reverse_o}, 4'b1110);

        go_reverse();

        // R4: plain data bytes, one with bit 7 set
        exp_q.push_back(8'h5A); send(1'b1, 8'h5A, 1'b0);
        exp_q.push_back(8'hC3); send(1'b1, 8'hC3, 1'b0);
        drain("R4 plain data delivered once");

        // R7 + R9: run of 3 extra copies with output stalls
        stall_en = 1'b1;
        send(1'b0, 8'h03, 1'b0);
        for (int i = 0; i < 4; i++) exp_q.push_back(8'hAB);
        send(1'b1, 8'hAB, 1'b0);
        drain("R7/R9 run expanded to four copies under stall");
        stall_en = 1'b0;

        // R8: channel address dropped, and does not disturb a pending count
        send(1'b0, 8'h85, 1'b0);
        exp_q.push_back(8'h11); send(1'b1, 8'h11, 1'b0);
        send(1'b0, 8'h02, 1'b0);
        send(1'b0, 8'h90, 1'b0);
        for (int i = 0; i < 3; i++) exp_q.push_back(8'h44);
        send(1'b1, 8'h44, 1'b0);
        drain("R8 channel address ignored");

        // R10: zero count, then plain data after expansion
        send(1'b0, 8'h00, 1'b0);
        exp_q.push_back(8'h22); send(1'b1, 8'h22, 1'b0);
        exp_q.push_back(8'h23); send(1'b1, 8'h23, 1'b0);
        drain("R10 zero count and post-run data single");

        // R5: peripheral holds nAck low after acknowledge
        t0 = tmo_cnt;
        exp_q.push_back(8'h77); send(1'b1, 8'h77, 1'b1);
        repeat (RESP + 6) @(negedge clk);
        check(tmo_cnt == t0 + 1, "R5 acknowledge timeout", tmo_cnt - t0, 1);
        check(!autofd_n_o && reverse_o, "R5 nAutoFd low after timeout", {autofd_n_o, reverse_o}, 2'b01);
        repeat (4) @(negedge clk);
        check(!out_valid_o, "R5 held byte not resampled", out_valid_o, 0);
        step(); ack_n = 1'b1;
        drain("R5 byte before ack timeout delivered once");

        // R6: idle timeout keeps reverse
        t0 = tmo_cnt;
        repeat (IDLE + 60) @(negedge clk);
        check(tmo_cnt == t0 + 1, "R6 idle timeout", tmo_cnt - t0, 1);
        check(reverse_o && !data_oe_o, "R6 stays in reverse", {reverse_o, data_oe_o}, 2'b10);
        exp_q.push_back(8'h66); send(1'b1, 8'h66, 1'b0);
        drain("R6 reception after idle timeout");

        // R11 + R12: handback clears a pending count
        send(1'b0, 8'h05, 1'b0);
        go_forward(1'b1);
        go_reverse();
        exp_q.push_back(8'h33); send(1'b1, 8'h33, 1'b0);
        drain("R12 pending run cleared by handback");

        // R11: handback with PError never rising
        go_forward(1'b0);

        summary();
    end
endmodule